// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block holds the setup registers of a four-channel serial peripheral. Host software reaches all of them through two byte-wide I/O locations: an index location that picks a register and a data location that reads or writes the register picked. After reset the register file is sealed. Software opens it by writing a key byte twice in a row to the index location, and closes it again with an exit byte. While the file is open, a logical-device-number register picks which channel's bank of per-channel registers sits behind the data location.

The decoded settings leave the block as plain outputs that the rest of the chip uses directly. Each channel gets a 16-bit I/O base address, an enable bit and a FIFO mode byte. All channels share one clock select byte. Host accesses arrive as a request stream. `req_ready` is tied high, so the block never applies back-pressure, and every request is taken in the cycle it is presented with `req_valid` high. Each read of the index or data location returns exactly one response beat on `rsp_valid`/`rsp_rdata` in the following cycle. That response cannot be stalled, so the host has to sample it in that cycle.

Top module: `keyed_cfg_port`

## Requirements
- R1: Reset leaves the file sealed, with the stored index at 0x00, the logical-device number at 0 and every output cleared: `ch_enable`, `ch_base`, `ch_fifo_mode` and `clk_sel`.
- R2: The file opens only when the key byte 0x67 is written to the index location (0x004E) twice with no other index-location write in between. Any other byte written there while sealed restarts the count. The key writes are not stored as the index.
- R3: While the file is sealed, writes to the data location (0x004F) change nothing, and reads of either location return 0xFF.
- R4: While the file is open, writing 0xAA to the index location seals it again. The stored index keeps its value.
- R5: Index 0x07 is the logical-device-number register. It can be read and written, and values 0 to 3 pick the bank of channel 0 to 3.
- R6: In the picked bank, index 0x60 holds bits 15:8 and index 0x61 holds bits 7:0 of that channel's `ch_base` field (bits 16*n+15 down to 16*n).
- R7: In the picked bank, bit 0 of index 0x30 drives that channel's bit of `ch_enable`. The other bits are not stored, so a read returns 0x00 or 0x01.
- R8: In the picked bank, index 0xF6 holds the FIFO mode byte, and that channel's `ch_fifo_mode` field (bits 8*n+7 down to 8*n) shows it.
- R9: Global index 0x25 is the clock select. It can be read and written and drives `clk_sel`. Indexes 0x23 and 0x24 read the high and low bytes of the vendor ID (0xA5C3 by default), and writes to them are dropped.
- R10: While the logical-device number is 4 or more, per-channel indexes read 0xFF and writes to them are dropped. The global registers still work.
- R11: `req_ready` is always 1. A read of the index or data location gives `rsp_valid` high in the next cycle only. Requests to any other address change nothing and give no response.
- R12: While the file is open, an index that maps to no register reads 0xFF, and writes to it are dropped. Reading the index location returns the stored index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Always 1; request taken the same cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Host I/O address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response beat, one cycle after the read |
| rsp_rdata | output | 8 | Read response byte |
| ch_enable | output | NCH | Per-channel enable |
| ch_base | output | 16*NCH | Per-channel I/O base address |
| ch_fifo_mode | output | 8*NCH | Per-channel FIFO mode byte |
| clk_sel | output | 8 | Global clock select byte |

## Verification
The unlock logic is driven with a clean key pair, a key pair broken by a stray byte, and an exit byte. These patterns separate a real two-in-a-row detector from one that counts any two keys or one that opens after a single key. Registers are programmed through two different logical-device numbers and then through one that is out of range. This shows whether bank selection steers writes to one channel alone and whether it blocks them when no channel matches. Writes to read-only, unmapped and foreign indexes or addresses are each followed by a readback through the ports, which shows that the write was dropped and not stored.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_BYTE    = 8'h67;
  localparam logic [7:0] EXIT_BYTE   = 8'hAA;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_VID_HI  = 8'h23;
  localparam logic [7:0] IDX_VID_LO  = 8'h24;
  localparam logic [7:0] IDX_CLKSEL  = 8'h25;
  localparam logic [7:0] IDX_ENABLE  = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_FIFO    = 8'hF6;
  localparam logic [7:0] NO_DATA     = 8'hFF;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_state_e;
endpackage

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wbyte,
  output logic       cfg_open
);
  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr) begin
      case (state_q)
        LK_SHUT: state_d = (wbyte == KEY_BYTE) ? LK_HALF : LK_SHUT;
        LK_HALF: state_d = (wbyte == KEY_BYTE) ? LK_OPEN : LK_SHUT;
        LK_OPEN: state_d = (wbyte == EXIT_BYTE) ? LK_SHUT : LK_OPEN;
        default: state_d = LK_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= LK_SHUT;
    else        state_q <= state_d;
  end

  assign cfg_open = (state_q == LK_OPEN);
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'hA5C3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] index,
  input  logic [7:0] wdata,
  output logic [7:0] ldn,
  output logic [7:0] clk_sel,
  output logic       hit,
  output logic [7:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldn     <= 8'h00;
      clk_sel <= 8'h00;
    end else if (wr_en) begin
      if (index == IDX_LDN)    ldn     <= wdata;
      if (index == IDX_CLKSEL) clk_sel <= wdata;
    end
  end

  always_comb begin
    hit   = 1'b1;
    rdata = NO_DATA;
    case (index)
      IDX_LDN:    rdata = ldn;
      IDX_CLKSEL: rdata = clk_sel;
      IDX_VID_HI: rdata = VENDOR_ID[15:8];
      IDX_VID_LO: rdata = VENDOR_ID[7:0];
      default:    hit   = 1'b0;
    endcase
  end
endmodule

// File: rtl/cfg_chan_bank.sv
module cfg_chan_bank
  import cfg_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  index,
  input  logic [7:0]  wdata,
  output logic        enable,
  output logic [15:0] base,
  output logic [7:0]  fifo_mode,
  output logic        hit,
  output logic [7:0]  rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable    <= 1'b0;
      base      <= 16'h0000;
      fifo_mode <= 8'h00;
    end else if (wr_en) begin
      case (index)
        IDX_ENABLE:  enable      <= wdata[0];
        IDX_BASE_HI: base[15:8]  <= wdata;
        IDX_BASE_LO: base[7:0]   <= wdata;
        IDX_FIFO:    fifo_mode   <= wdata;
        default:     ;
      endcase
    end
  end

  always_comb begin
    hit   = 1'b1;
    rdata = NO_DATA;
    case (index)
      IDX_ENABLE:  rdata = {7'b0, enable};
      IDX_BASE_HI: rdata = base[15:8];
      IDX_BASE_LO: rdata = base[7:0];
      IDX_FIFO:    rdata = fifo_mode;
      default:     hit   = 1'b0;
    endcase
  end
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int          NCH       = 4,
  parameter logic [15:0] IDX_PORT  = 16'h004E,
  parameter logic [15:0] DAT_PORT  = 16'h004F,
  parameter logic [15:0] VENDOR_ID = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [15:0]       req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic [7:0]        rsp_rdata,
  output logic [NCH-1:0]    ch_enable,
  output logic [16*NCH-1:0] ch_base,
  output logic [8*NCH-1:0]  ch_fifo_mode,
  output logic [7:0]        clk_sel
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic            idx_sel, dat_sel, idx_wr, dat_wr, rd_acc;
  logic            cfg_open;
  logic [7:0]      index_q;
  logic [7:0]      ldn;
  logic            ldn_ok;
  logic [CH_W-1:0] ch_pick;
  logic            glb_hit;
  logic [7:0]      glb_rdata;
  logic            bank_hit   [NCH];
  logic [7:0]      bank_rdata [NCH];
  logic [7:0]      rd_val;

  assign req_ready = 1'b1;
  assign idx_sel   = req_valid && (req_addr == IDX_PORT);
  assign dat_sel   = req_valid && (req_addr == DAT_PORT);
  assign idx_wr    = idx_sel && req_write;
  assign dat_wr    = dat_sel && req_write && cfg_open;
  assign rd_acc    = (idx_sel || dat_sel) && !req_write;

  cfg_unlock_fsm u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .wbyte    (req_wdata),
    .cfg_open (cfg_open)
  );

  // Index register: only loaded while open; the exit byte is not stored.
  always_ff @(posedge clk) begin
    if (!rst_n)
      index_q <= 8'h00;
    else if (idx_wr && cfg_open && (req_wdata != EXIT_BYTE))
      index_q <= req_wdata;
  end

  cfg_global_regs #(.VENDOR_ID(VENDOR_ID)) u_glb (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dat_wr),
    .index   (index_q),
    .wdata   (req_wdata),
    .ldn     (ldn),
    .clk_sel (clk_sel),
    .hit     (glb_hit),
    .rdata   (glb_rdata)
  );

  assign ldn_ok  = (ldn < 8'(NCH));
  assign ch_pick = ldn[CH_W-1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_bank
    logic bank_wr;
    assign bank_wr = dat_wr && ldn_ok && (ch_pick == CH_W'(g));

    cfg_chan_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bank_wr),
      .index     (index_q),
      .wdata     (req_wdata),
      .enable    (ch_enable[g]),
      .base      (ch_base[16*g +: 16]),
      .fifo_mode (ch_fifo_mode[8*g +: 8]),
      .hit       (bank_hit[g]),
      .rdata     (bank_rdata[g])
    );
  end

  always_comb begin
    rd_val = NO_DATA;
    if (cfg_open) begin
      if (idx_sel)                          rd_val = index_q;
      else if (glb_hit)                     rd_val = glb_rdata;
      else if (ldn_ok && bank_hit[ch_pick]) rd_val = bank_rdata[ch_pick];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 8'h00;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk
  import cfg_port_pkg::*;
#(
  parameter int          NCH      = 4,
  parameter logic [15:0] IDX_PORT = 16'h004E,
  parameter logic [15:0] DAT_PORT = 16'h004F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [15:0]       req_addr,
  input logic [7:0]        req_wdata,
  input logic              rsp_valid,
  input logic [7:0]        rsp_rdata,
  input logic              cfg_open,
  input logic [NCH-1:0]    ch_enable,
  input logic [16*NCH-1:0] ch_base,
  input logic [8*NCH-1:0]  ch_fifo_mode,
  input logic [7:0]        clk_sel
);
  logic port_rd, idx_write, dat_write;
  assign port_rd   = req_valid && !req_write &&
                     ((req_addr == IDX_PORT) || (req_addr == DAT_PORT));
  assign idx_write = req_valid && req_write && (req_addr == IDX_PORT);
  assign dat_write = req_valid && req_write && (req_addr == DAT_PORT);

  p_always_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);

  p_rsp_follows_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd |=> rsp_valid);

  p_no_stray_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !port_rd |=> !rsp_valid);

  p_sealed_read_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && port_rd) |=> (rsp_rdata == NO_DATA));

  p_sealed_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && dat_write) |=>
      ($stable(ch_enable) && $stable(ch_base) && $stable(ch_fifo_mode) && $stable(clk_sel)));

  p_exit_seals_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && idx_write && req_wdata == EXIT_BYTE) |=> !cfg_open);

  p_open_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(idx_write && req_wdata == KEY_BYTE));
endmodule

bind keyed_cfg_port cfg_port_chk #(
  .NCH(NCH), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .cfg_open     (cfg_open),
  .ch_enable    (ch_enable),
  .ch_base      (ch_base),
  .ch_fifo_mode (ch_fifo_mode),
  .clk_sel      (clk_sel)
);

// File: tb/keyed_cfg_port_test.sv
`timescale 1ns/1ps
module keyed_cfg_port_test;
  localparam int NCH = 4;
  localparam logic [15:0] IP = 16'h004E;
  localparam logic [15:0] DP = 16'h004F;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [15:0]       req_addr = 16'h0;
  logic [7:0]        req_wdata = 8'h0;
  logic              rsp_valid;
  logic [7:0]        rsp_rdata;
  logic [NCH-1:0]    ch_enable;
  logic [16*NCH-1:0] ch_base;
  logic [8*NCH-1:0]  ch_fifo_mode;
  logic [7:0]        clk_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keyed_cfg_port #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ch_enable(ch_enable),
    .ch_base(ch_base), .ch_fifo_mode(ch_fifo_mode), .clk_sel(clk_sel)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    v = rsp_valid; d = rsp_rdata;
  endtask

  task automatic chk_rd(input string tag, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] d; logic v;
    rd(a, d, v);
    check({tag, " rsp_valid"}, 64'(v), 64'd1);
    check({tag, " data"}, 64'(d), 64'(exp));
  endtask

  task automatic set_reg(input logic [7:0] idx, input logic [7:0] val);
    wr(IP, idx); wr(DP, val);
  endtask

  task automatic unlock();
    wr(IP, 8'h67); wr(IP, 8'h67);
  endtask

  task automatic t_reset();
    check("R1 enable", 64'(ch_enable), 64'd0);
    check("R1 base", 64'(ch_base), 64'd0);
    check("R1 fifo", 64'(ch_fifo_mode), 64'd0);
    check("R1 clk_sel", 64'(clk_sel), 64'd0);
    chk_rd("R1 sealed data read", DP, 8'hFF);
    unlock();
    chk_rd("R1 index after reset", IP, 8'h00);
    set_reg(8'h07, 8'h00);
    wr(IP, 8'h07);
    chk_rd("R1 ldn after reset", DP, 8'h00);
    wr(IP, 8'hAA);
  endtask

  task automatic t_unlock();
    wr(IP, 8'h67); wr(IP, 8'h00); wr(IP, 8'h67);
    chk_rd("R2 broken key stays sealed", IP, 8'hFF);
    wr(IP, 8'h67);
    chk_rd("R2 second key opens, index kept", IP, 8'h07);
    wr(IP, 8'hAA);
    wr(IP, 8'h67);
    chk_rd("R2 single key stays sealed", IP, 8'hFF);
    wr(IP, 8'h10);
  endtask

  task automatic t_sealed_ignore();
    unlock();
    wr(IP, 8'h25);
    wr(IP, 8'hAA);
    wr(DP, 8'h5A);
    check("R3 clk_sel unchanged while sealed", 64'(clk_sel), 64'd0);
    chk_rd("R3 sealed index read", IP, 8'hFF);
    unlock();
    chk_rd("R4 index kept over seal", IP, 8'h25);
    chk_rd("R3 write dropped readback", DP, 8'h00);
  endtask

  task automatic t_channel0();
    set_reg(8'h07, 8'h00);
    set_reg(8'h60, 8'h03);
    set_reg(8'h61, 8'hF8);
    check("R6 ch0 base", 64'(ch_base[15:0]), 64'h03F8);
    set_reg(8'h30, 8'hFF);
    check("R7 ch0 enable", 64'(ch_enable), 64'b0001);
    chk_rd("R7 enable reads bit0 only", DP, 8'h01);
    set_reg(8'hF6, 8'h25);
    check("R8 ch0 fifo", 64'(ch_fifo_mode[7:0]), 64'h25);
    chk_rd("R8 fifo readback", DP, 8'h25);
    wr(IP, 8'h60);
    chk_rd("R6 base hi readback", DP, 8'h03);
  endtask

  task automatic t_multi();
    set_reg(8'h07, 8'h02);
    chk_rd("R5 ldn readback", DP, 8'h02);
    set_reg(8'h60, 8'h02);
    set_reg(8'h61, 8'hE8);
    set_reg(8'h30, 8'h01);
    check("R5 ch2 base", 64'(ch_base[47:32]), 64'h02E8);
    check("R5 ch0 base untouched", 64'(ch_base[15:0]), 64'h03F8);
    check("R5 enables", 64'(ch_enable), 64'b0101);
    set_reg(8'h07, 8'h03);
    set_reg(8'hF6, 8'h40);
    check("R8 ch3 fifo", 64'(ch_fifo_mode), 64'h4000_0025);
    wr(IP, 8'h30);
    chk_rd("R5 ch3 enable read", DP, 8'h00);
  endtask

  task automatic t_bad_ldn();
    set_reg(8'h07, 8'h04);
    set_reg(8'h60, 8'h77);
    set_reg(8'h30, 8'h01);
    check("R10 bases unchanged", 64'(ch_base), 64'h0000_02E8_0000_03F8);
    check("R10 enables unchanged", 64'(ch_enable), 64'b0101);
    wr(IP, 8'h60);
    chk_rd("R10 per-channel read FF", DP, 8'hFF);
    set_reg(8'h25, 8'h11);
    check("R10 global still writes", 64'(clk_sel), 64'h11);
    wr(IP, 8'h07);
    chk_rd("R10 ldn readback", DP, 8'h04);
  endtask

  task automatic t_global();
    set_reg(8'h25, 8'h02);
    check("R9 clk_sel", 64'(clk_sel), 64'h02);
    chk_rd("R9 clk_sel readback", DP, 8'h02);
    wr(IP, 8'h23);
    chk_rd("R9 vendor hi", DP, 8'hA5);
    wr(DP, 8'h00);
    chk_rd("R9 vendor hi read-only", DP, 8'hA5);
    wr(IP, 8'h24);
    chk_rd("R9 vendor lo", DP, 8'hC3);
  endtask

  task automatic t_unknown();
    set_reg(8'h07, 8'h00);
    set_reg(8'h55, 8'h12);
    chk_rd("R12 unmapped read", DP, 8'hFF);
    chk_rd("R12 index readback", IP, 8'h55);
    check("R12 outputs unchanged", 64'(ch_base), 64'h0000_02E8_0000_03F8);
    check("R12 clk_sel unchanged", 64'(clk_sel), 64'h02);
  endtask

  task automatic t_relock();
    wr(IP, 8'hAA);
    chk_rd("R4 sealed after exit", DP, 8'hFF);
    chk_rd("R4 index sealed after exit", IP, 8'hFF);
  endtask

  task automatic t_other_addr();
    logic [7:0] d; logic v;
    unlock();
    set_reg(8'h07, 8'h00);
    wr(IP, 8'h61);
    wr(16'h03F8, 8'h99);
    wr(16'h004D, 8'h99);
    chk_rd("R11 foreign write dropped", DP, 8'hF8);
    rd(16'h0080, d, v);
    check("R11 no response to foreign read", 64'(v), 64'd0);
    check("R11 ready high", 64'(req_ready), 64'd1);
    @(negedge clk);
    check("R11 no response when idle", 64'(rsp_valid), 64'd0);
    wr(IP, 8'hAA);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unlock();
    t_sealed_ignore();
    t_channel0();
    t_multi();
    t_bad_ldn();
    t_global();
    t_unknown();
    t_relock();
    t_other_addr();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule